// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block decides whether a receive line has lost its signal. It watches two inputs. One is the recovered bit stream, qualified by a per-bit strobe. The other is a level flag from the analog front end, which says the received level is below the chosen threshold. Loss is declared in either of two cases. The first is that the level flag stays set for one millisecond of line bits without a break: 1544 bit slots in T1 mode and 2048 in E1 mode. The second is that more than 192 zeros arrive in a row. A registered status bit holds the result.

The status bit clears as soon as a one arrives while the level flag is low. The same event restarts both the level timer and the zero-run counter. Reset leaves the status asserted, so loss is reported until valid signal has been seen.

The block also drives an external loss pin and a threshold choice for the front end. The pin shows loss of signal, loss of frame alignment, or the OR of both, under two enable bits. The frame-alignment loss is an input from the frame aligner. The threshold output follows a select bit in E1 mode and is fixed at the deeper level in T1 mode.

Top module: `line_los_detector`

## Requirements
- R1: Reset (rst_n low) sets los_status to 1. While reset is held, los_pin follows the pin enables with loss-of-signal taken as 1.
- R2: los_status becomes 1 after below_thr has been 1 on a run of consecutive bit slots (bit_en high). The run length is 1544 slots when e1_mode is 0 and 2048 slots when e1_mode is 1. A run one slot shorter does not set it.
- R3: A bit slot with below_thr at 0 restarts the level run. Two runs one slot short of the terminal count, separated by one such slot, do not set los_status.
- R4: los_status becomes 1 after 193 consecutive zero bits (rx_bit 0 on bit slots). 192 consecutive zeros do not set it.
- R5: The zero-run count saturates above the limit and never wraps. los_status stays 1 through a run of 800 zeros.
- R6: A bit slot with rx_bit 1 and below_thr 0 clears los_status on the next clock. A one received with below_thr 1 does not clear it.
- R7: The clearing event restarts the zero-run count and the level timer. 150 zeros, then a clearing one, then 150 more zeros leaves los_status at 0.
- R8: los_pin = (pin_sel_los AND los_status) OR (pin_sel_frm AND frame_loss). With both enables 0, los_pin is 0.
- R9: thr_40db is 1 (-40 dB) whenever e1_mode is 0. When e1_mode is 1, thr_40db equals thr_sel, where 0 selects -20 dB.
- R10: Cycles with bit_en low do not count, restart or clear anything, whatever rx_bit and below_thr carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe marking a recovered bit slot |
| rx_bit | input | 1 | Recovered line bit |
| below_thr | input | 1 | Front-end flag: received level under threshold |
| e1_mode | input | 1 | 1 = E1 (2048 slots/ms), 0 = T1 (1544 slots/ms) |
| thr_sel | input | 1 | E1 threshold select: 1 = -40 dB, 0 = -20 dB |
| frame_loss | input | 1 | Loss of basic frame alignment from the aligner |
| pin_sel_los | input | 1 | Enable loss-of-signal onto los_pin |
| pin_sel_frm | input | 1 | Enable frame loss onto los_pin |
| los_status | output | 1 | Loss-of-signal status |
| los_pin | output | 1 | External loss indication |
| thr_40db | output | 1 | Threshold to the front end: 1 = -40 dB, 0 = -20 dB |

## Verification
The level timer is driven with runs of low-level slots that end one slot short of the terminal count, or exactly on it, in both line modes. A single-slot break is placed between two short runs, which tells a consecutive-slot timer apart from a cumulative one. Zero runs of 192, 193 and 800 bits, and runs split by a clearing one, separate the strict "more than" boundary, saturation and restart on clear. A vector table over every pin enable, frame-loss and mode combination, taken with the status both set and clear, fixes the pin and threshold logic. Idle cycles with active-looking data check that unstrobed cycles are ignored.

// File: rtl/los_pkg.sv
package los_pkg;
   // One millisecond of line bits at each rate
   localparam int unsigned T1_SLOTS_PER_MS = 1544;
   localparam int unsigned E1_SLOTS_PER_MS = 2048;
   // Zero run must exceed this to declare loss
   localparam int unsigned ZERO_RUN_LIMIT  = 192;

   typedef struct packed {
      logic show_los;
      logic show_frm;
   } los_pin_sel_t;
endpackage

// File: rtl/los_level_timer.sv
module los_level_timer #(
   parameter int unsigned T1_TERM = 1544,
   parameter int unsigned E1_TERM = 2048,
   localparam int unsigned MAX_TERM = (T1_TERM > E1_TERM) ? T1_TERM : E1_TERM,
   localparam int unsigned CNT_W = $clog2(MAX_TERM + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic level_low,
   input  logic restart,
   input  logic e1_mode,
   output logic expired
);
   if (T1_TERM < 2 || E1_TERM < 2) begin : g_bad_term
      $error("los_level_timer: terminal counts must be at least 2");
   end

   localparam logic [CNT_W-1:0] T1_LIM = CNT_W'(T1_TERM);
   localparam logic [CNT_W-1:0] E1_LIM = CNT_W'(E1_TERM);

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] term;

   assign term = e1_mode ? E1_LIM : T1_LIM;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         run_q <= '0;
      end else if (tick) begin
         if (!level_low) begin
            run_q <= '0;
         end else if (run_q < term) begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign expired = (run_q >= term);

   // R2: the run count never climbs past the larger terminal value
   assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= CNT_W'(MAX_TERM));

   // R3: a level-ok slot restarts the run
   assert_break_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !level_low) |=> (run_q == '0));

   // R10: no strobe, no restart request -> run count holds
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(run_q));
endmodule

// File: rtl/los_zero_run.sv
module los_zero_run #(
   parameter int unsigned LIMIT = 192,
   localparam int unsigned SAT = LIMIT + 1,
   localparam int unsigned CNT_W = $clog2(SAT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic bit_in,
   input  logic restart,
   output logic run_long
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("los_zero_run: LIMIT must be at least 1");
   end

   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

   logic [CNT_W-1:0] zeros_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         zeros_q <= '0;
      end else if (tick) begin
         if (bit_in) begin
            zeros_q <= '0;
         end else if (zeros_q != SAT_V) begin
            zeros_q <= zeros_q + 1'b1;
         end
      end
   end

   assign run_long = (zeros_q == SAT_V);

   // R5: count stays within the saturation value
   assert_zero_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      zeros_q <= SAT_V);

   // R5: once saturated, further zeros keep it saturated (no wrap)
   assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_long && tick && !bit_in && !restart) |=> run_long);

   // R4: a received one ends the run
   assert_one_ends_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && bit_in) |=> !run_long);
endmodule

// File: rtl/los_pin_mux.sv
module los_pin_mux #(
   parameter bit PIN_REG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  los_pkg::los_pin_sel_t sel,
   input  logic                  loss_sig,
   input  logic                  frame_loss,
   input  logic                  e1_mode,
   input  logic                  thr_sel,
   output logic                  pin,
   output logic                  thr_40db
);
   logic pin_d;

   assign pin_d    = (sel.show_los & loss_sig) | (sel.show_frm & frame_loss);
   assign thr_40db = e1_mode ? thr_sel : 1'b1;

   if (PIN_REG) begin : g_pin_flop
      logic pin_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pin_q <= 1'b0;
         else        pin_q <= pin_d;
      end
      assign pin = pin_q;

      // R8: both enables off -> pin low on the next cycle
      assert_pin_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!sel.show_los && !sel.show_frm) |=> !pin);
   end else begin : g_pin_comb
      assign pin = pin_d;

      // R8: both enables off -> pin low
      assert_pin_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!sel.show_los && !sel.show_frm) |-> !pin);
   end

   // R9: T1 always asks for the deep threshold
   assert_t1_thr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !e1_mode |-> thr_40db);
endmodule

// File: rtl/line_los_detector.sv
module line_los_detector #(
   parameter int unsigned T1_TERM    = los_pkg::T1_SLOTS_PER_MS,
   parameter int unsigned E1_TERM    = los_pkg::E1_SLOTS_PER_MS,
   parameter int unsigned ZERO_LIMIT = los_pkg::ZERO_RUN_LIMIT,
   parameter bit          PIN_REG    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic below_thr,
   input  logic e1_mode,
   input  logic thr_sel,
   input  logic frame_loss,
   input  logic pin_sel_los,
   input  logic pin_sel_frm,
   output logic los_status,
   output logic los_pin,
   output logic thr_40db
);
   logic                  good_one;
   logic                  level_timeout;
   logic                  zeros_long;
   logic                  status_q;
   los_pkg::los_pin_sel_t pin_sel;

   // A one at adequate level is proof of signal
   assign good_one = bit_en & rx_bit & ~below_thr;

   los_level_timer #(
      .T1_TERM (T1_TERM),
      .E1_TERM (E1_TERM)
   ) u_level_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (bit_en),
      .level_low (below_thr),
      .restart   (good_one),
      .e1_mode   (e1_mode),
      .expired   (level_timeout)
   );

   los_zero_run #(
      .LIMIT (ZERO_LIMIT)
   ) u_zero_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (bit_en),
      .bit_in   (rx_bit),
      .restart  (good_one),
      .run_long (zeros_long)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= 1'b1;
      end else if (good_one) begin
         status_q <= 1'b0;
      end else if (level_timeout || zeros_long) begin
         status_q <= 1'b1;
      end
   end

   assign los_status       = status_q;
   assign pin_sel.show_los = pin_sel_los;
   assign pin_sel.show_frm = pin_sel_frm;

   los_pin_mux #(
      .PIN_REG (PIN_REG)
   ) u_pin_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (pin_sel),
      .loss_sig   (status_q),
      .frame_loss (frame_loss),
      .e1_mode    (e1_mode),
      .thr_sel    (thr_sel),
      .pin        (los_pin),
      .thr_40db   (thr_40db)
   );

   // R6: a good one clears the status on the next clock
   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      good_one |=> !los_status);

   // R4: a long zero run without a clearing one sets the status
   assert_zero_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (zeros_long && !good_one) |=> los_status);

   // R2: a level timeout without a clearing one sets the status
   assert_level_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (level_timeout && !good_one) |=> los_status);

   // R10: the status only falls on a strobed slot
   assert_fall_needs_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(los_status) |-> $past(bit_en));
endmodule

// File: tb/line_los_detector_bench.sv
module line_los_detector_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, rx_bit = 1'b0, below_thr = 1'b0;
   logic e1_mode = 1'b0, thr_sel = 1'b0, frame_loss = 1'b0;
   logic pin_sel_los = 1'b0, pin_sel_frm = 1'b0;
   logic los_status, los_pin, thr_40db;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   line_los_detector u_line_los_detector (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .below_thr(below_thr), .e1_mode(e1_mode), .thr_sel(thr_sel),
      .frame_loss(frame_loss), .pin_sel_los(pin_sel_los),
      .pin_sel_frm(pin_sel_frm), .los_status(los_status),
      .los_pin(los_pin), .thr_40db(thr_40db)
   );

   // Row: [7] want status, [6] sel_los, [5] sel_frm, [4] frame_loss,
   //      [3] e1_mode, [2] thr_sel, [1] expected pin, [0] expected thr_40db
   localparam logic [7:0] VEC [8] = '{
      8'b1_1_0_0_0_0_1_1,
      8'b1_0_0_1_1_0_0_0,
      8'b1_0_1_0_1_1_0_1,
      8'b1_1_1_0_0_1_1_1,
      8'b0_1_0_1_0_0_0_1,
      8'b0_0_1_1_1_0_1_0,
      8'b0_1_1_1_1_1_1_1,
      8'b0_0_0_1_0_0_0_1
   };

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // Drive n strobed bit slots, then two idle cycles for the status to settle
   task automatic slots(input int n, input logic b, input logic low);
      for (int i = 0; i < n; i++) begin
         bit_en = 1'b1; rx_bit = b; below_thr = low;
         @(negedge clk);
      end
      bit_en = 1'b0; rx_bit = 1'b0; below_thr = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_los();
      slots(1, 1'b1, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic cur;
      pin_sel_los = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 status in reset", los_status, 1'b1);
      check("R1 pin in reset", los_pin, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status after reset", los_status, 1'b1);

      // Vector table for pin select and threshold
      cur = 1'b1;
      for (int r = 0; r < 8; r++) begin
         if (VEC[r][7] != cur) begin
            if (VEC[r][7]) slots(193, 1'b0, 1'b0);
            else           clear_los();
            cur = VEC[r][7];
         end
         pin_sel_los = VEC[r][6]; pin_sel_frm = VEC[r][5];
         frame_loss  = VEC[r][4]; e1_mode     = VEC[r][3];
         thr_sel     = VEC[r][2];
         @(negedge clk);
         check("R8 pin select vector", los_pin, VEC[r][1]);
         check("R9 threshold vector", thr_40db, VEC[r][0]);
      end
      pin_sel_los = 1'b1; pin_sel_frm = 1'b0; frame_loss = 1'b0;

      // R2 level timeout, T1
      e1_mode = 1'b0;
      clear_los();
      check("R6 good one clears", los_status, 1'b0);
      slots(1543, 1'b1, 1'b1);
      check("R2 T1 one slot short", los_status, 1'b0);
      slots(1, 1'b1, 1'b1);
      check("R2 T1 at 1544 slots", los_status, 1'b1);
      check("R8 pin shows loss", los_pin, 1'b1);

      // R6 a one at low level does not clear
      slots(1, 1'b1, 1'b1);
      check("R6 one below threshold keeps loss", los_status, 1'b1);

      // R3 break restarts
      clear_los();
      slots(1543, 1'b1, 1'b1);
      slots(1, 1'b0, 1'b0);
      slots(1543, 1'b1, 1'b1);
      check("R3 break restarts level run", los_status, 1'b0);
      slots(1, 1'b1, 1'b1);
      check("R3 full run after break", los_status, 1'b1);

      // R2 E1
      e1_mode = 1'b1;
      clear_los();
      slots(2047, 1'b1, 1'b1);
      check("R2 E1 one slot short", los_status, 1'b0);
      slots(1, 1'b1, 1'b1);
      check("R2 E1 at 2048 slots", los_status, 1'b1);
      e1_mode = 1'b0;

      // R4 zero run
      clear_los();
      slots(192, 1'b0, 1'b0);
      check("R4 192 zeros", los_status, 1'b0);
      slots(1, 1'b0, 1'b0);
      check("R4 193 zeros", los_status, 1'b1);

      // R5 saturation
      slots(607, 1'b0, 1'b0);
      check("R5 800 zeros stays asserted", los_status, 1'b1);
      clear_los();
      slots(192, 1'b0, 1'b0);
      check("R5 run after saturation restarts", los_status, 1'b0);

      // R7 clear restarts counters
      clear_los();
      slots(150, 1'b0, 1'b0);
      clear_los();
      slots(150, 1'b0, 1'b0);
      check("R7 zero count restarted by clear", los_status, 1'b0);
      clear_los();
      slots(1000, 1'b1, 1'b1);
      clear_los();
      slots(1000, 1'b1, 1'b1);
      check("R7 level timer restarted by clear", los_status, 1'b0);

      // R10 unstrobed cycles ignored
      clear_los();
      slots(192, 1'b0, 1'b0);
      rx_bit = 1'b0; below_thr = 1'b1;
      repeat (3000) @(negedge clk);
      below_thr = 1'b0;
      @(negedge clk);
      check("R10 idle cycles do not count", los_status, 1'b0);
      slots(1, 1'b0, 1'b0);
      check("R10 run resumes after idle", los_status, 1'b1);
      rx_bit = 1'b1; below_thr = 1'b0;
      repeat (5) @(negedge clk);
      check("R10 idle one does not clear", los_status, 1'b1);
      rx_bit = 1'b0;

      // R8 both enables off
      pin_sel_los = 1'b0; pin_sel_frm = 1'b0; frame_loss = 1'b1;
      @(negedge clk);
      check("R8 pin off with no enables", los_pin, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule